// File: doc/BRIEF.md
# Graphics Command Stream Packet Decoder

This block sits behind a byte-wide graphics command FIFO and turns each command packet into one or more 32-bit register writes. A write lands in one of three register spaces: the transform unit, the rasterizer back end, and the command processor. The opcode byte at the head of a packet selects the space and the packet's length. Every 32-bit operand is assembled big-endian from four consecutive stream bytes.

Transform-unit packets carry a header word holding a start address and a word count. The decoder emits one write per data word and steps the address by one each time. It sorts each address into a memory or register region. Addresses that fall into no region are consumed without a write. Command-processor writes are tagged when they target an array base or array stride register. Unknown opcodes set a sticky error flag and are discarded byte by byte. Exactly one write can be held at the output. The byte input stalls only while that write waits for the downstream consumer.

Top module: `cmdq_decoder`

## Requirements
- R1: After reset, `wr_valid` is 0, `err_flag` is 0 and `in_ready` is 1.
- R2: Opcode 0x61 is followed by one word W. It yields a single write with `wr_space`=1, `wr_addr`=W[31:24], `wr_data`={8'h00, W[23:0]} and `wr_region`=7.
- R3: Opcode 0x08 is followed by a selector byte S and then a word W. It yields a write with `wr_space`=2, `wr_addr`=S and `wr_data`=W. `wr_region` is 5 when S[7:4]=10 and S[3:0]<4, 6 when S[7:4]=11 and S[3:0]<4, and 7 otherwise.
- R4: Opcode 0x10 is followed by a header word H and then H[31:16]+1 data words. The k-th data word (k from 0) targets address H[15:0]+k, with the address wrapping at 16 bits, and is written with `wr_space`=0.
- R5: Each transform write carries a region code. Addresses below 0x400 give 0, 0x400–0x4FF give 1, 0x500–0x5FF give 2, 0x600–0x67F give 3, and 0x1000–0x104F give 4.
- R6: A transform data word whose address lies in none of the R5 ranges is consumed and produces no write. The words after it in the same packet are still processed.
- R7: Opcode 0x00 is consumed and produces no write and no error.
- R8: Any opcode other than 0x00, 0x08, 0x10 or 0x61 sets `err_flag`, which stays set until reset. The byte is dropped, and the next byte is decoded as an opcode.
- R9: While `wr_valid`=1 and `wr_ready`=0, the write's space, address, data and region stay stable and `in_ready` is 0. At all other times `in_ready` is 1.
- R10: Operand words are big-endian: the first byte of a word lands in bits 31:24 and the fourth in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Consumer takes the pending write |
| wr_space | output | 2 | Target space: 0 transform, 1 back end, 2 command processor |
| wr_addr | output | 16 | Register address within the space |
| wr_data | output | 32 | Write data |
| wr_region | output | 3 | Region or register class code (R3, R5) |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
The embedded properties check the following on every cycle:
- the pending write stays still under backpressure;
- the error flag never clears;
- a transform write never leaves the valid address ranges;
- light-region tags match their addresses;
- back-end writes keep their upper bits clear.

Only the bench's scenarios can show that writes appear in the right number and order, and that header counts are honoured. They also show that rejected addresses really vanish while the rest of a packet goes on. Finally, they show that a discarded opcode leaves the next packet intact. Sweeps cover every selector byte, every opcode value and every region boundary, with and without downstream stalls.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;

  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_CP  = 8'h08;
  localparam logic [7:0] OP_XF  = 8'h10;
  localparam logic [7:0] OP_BP  = 8'h61;

  localparam logic [15:0] XF_MTX_END   = 16'h0400;
  localparam logic [15:0] XF_NRM_END   = 16'h0500;
  localparam logic [15:0] XF_DTX_END   = 16'h0600;
  localparam logic [15:0] XF_LIGHT_END = 16'h0680;
  localparam logic [15:0] XF_REG_BASE  = 16'h1000;
  localparam logic [15:0] XF_REG_NUM   = 16'h0050;

  typedef enum logic [1:0] {SP_XF = 2'd0, SP_BP = 2'd1, SP_CP = 2'd2} space_e;

  typedef enum logic [2:0] {
    RG_MTX = 3'd0, RG_NRM = 3'd1, RG_DTX = 3'd2, RG_LIGHT = 3'd3,
    RG_XFREG = 3'd4, RG_ARRBASE = 3'd5, RG_ARRSTRIDE = 3'd6, RG_GEN = 3'd7
  } region_e;

  typedef enum logic [1:0] {ST_OP = 2'd0, ST_SEL = 2'd1, ST_WORD = 2'd2} state_e;
  typedef enum logic [1:0] {K_BP = 2'd0, K_CP = 2'd1, K_XFHDR = 2'd2, K_XFDAT = 2'd3} kind_e;
endpackage

// File: rtl/cmdq_word_asm.sv
module cmdq_word_asm #(
  parameter int BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  logic [7:0]           byte_i,
  output logic                 done_o,
  output logic [BYTES*8-1:0]   word_o
);
  localparam int CNT_W = $clog2(BYTES);
  localparam int ACC_W = (BYTES - 1) * 8;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [ACC_W-1:0] acc_q, acc_n;

  always_comb begin
    cnt_n = cnt_q;
    acc_n = acc_q;
    if (take_i) begin
      cnt_n = (cnt_q == CNT_W'(BYTES - 1)) ? '0 : cnt_q + 1'b1;
      acc_n = {acc_q[ACC_W-9:0], byte_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_n;
      acc_q <= acc_n;
    end
  end

  assign done_o = take_i && (cnt_q == CNT_W'(BYTES - 1));
  assign word_o = {acc_q, byte_i};
endmodule

// File: rtl/cmdq_xf_class.sv
module cmdq_xf_class
  import cmdq_pkg::*;
(
  input  logic [15:0] addr_i,
  output region_e     region_o,
  output logic        hit_o
);
  always_comb begin
    hit_o    = 1'b1;
    region_o = RG_GEN;
    if (addr_i < XF_MTX_END)                region_o = RG_MTX;
    else if (addr_i < XF_NRM_END)           region_o = RG_NRM;
    else if (addr_i < XF_DTX_END)           region_o = RG_DTX;
    else if (addr_i < XF_LIGHT_END)         region_o = RG_LIGHT;
    else if (addr_i >= XF_REG_BASE && addr_i < XF_REG_BASE + XF_REG_NUM)
                                            region_o = RG_XFREG;
    else                                    hit_o    = 1'b0;
  end
endmodule

// File: rtl/cmdq_cp_class.sv
module cmdq_cp_class
  import cmdq_pkg::*;
#(
  parameter logic [3:0] BASE_SEL   = 4'd10,
  parameter logic [3:0] STRIDE_SEL = 4'd11,
  parameter int         ARRAYS     = 4
) (
  input  logic [7:0] sel_i,
  output region_e    region_o
);
  logic idx_ok;
  assign idx_ok = (int'(sel_i[3:0]) < ARRAYS);

  always_comb begin
    region_o = RG_GEN;
    if (idx_ok && sel_i[7:4] == BASE_SEL)        region_o = RG_ARRBASE;
    else if (idx_ok && sel_i[7:4] == STRIDE_SEL) region_o = RG_ARRSTRIDE;
  end
endmodule

// File: rtl/cmdq_out_stage.sv
module cmdq_out_stage
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  space_e            space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  region_e           region_i,
  input  logic              ready_i,
  output logic              valid_o,
  output space_e            space_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output region_e           region_o,
  output logic              free_o
);
  logic valid_n;

  always_comb begin
    valid_n = valid_o;
    if (load_i)       valid_n = 1'b1;
    else if (ready_i) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_o  <= SP_XF;
      addr_o   <= '0;
      data_o   <= '0;
      region_o <= RG_GEN;
    end else if (load_i) begin
      space_o  <= space_i;
      addr_o   <= addr_i;
      data_o   <= data_i;
      region_o <= region_i;
    end
  end

  assign free_o = !valid_o || ready_i;

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o)
                            && $stable(space_o) && $stable(region_o)); // R9
endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [1:0]        wr_space,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [2:0]        wr_region,
  output logic              err_flag
);
  localparam int BYTES = WORD_W / BYTE_W;

  state_e st_q, st_n;
  kind_e  kind_q, kind_n;
  logic [7:0]  sel_q, sel_n;
  logic [15:0] xa_q, xa_n, xl_q, xl_n;
  logic        err_q, err_n;

  logic              take, word_done, xf_hit, emit;
  logic [WORD_W-1:0] word;
  region_e           xf_region, cp_region, e_region, o_region;
  space_e            e_space, o_space;
  logic [ADDR_W-1:0] e_addr;
  logic [WORD_W-1:0] e_data;

  assign take = in_valid && in_ready;

  cmdq_word_asm #(.BYTES(BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .take_i(take && st_q == ST_WORD),
    .byte_i(in_byte), .done_o(word_done), .word_o(word));

  cmdq_xf_class u_xf (.addr_i(xa_q), .region_o(xf_region), .hit_o(xf_hit));

  cmdq_cp_class u_cp (.sel_i(sel_q), .region_o(cp_region));

  always_comb begin
    st_n = st_q; kind_n = kind_q; sel_n = sel_q;
    xa_n = xa_q; xl_n = xl_q; err_n = err_q;
    emit = 1'b0; e_space = SP_BP; e_addr = '0; e_data = '0; e_region = RG_GEN;
    if (take) begin
      case (st_q)
        ST_OP: begin
          case (in_byte)
            OP_NOP: ;
            OP_CP:  st_n = ST_SEL;
            OP_XF:  begin st_n = ST_WORD; kind_n = K_XFHDR; end
            OP_BP:  begin st_n = ST_WORD; kind_n = K_BP; end
            default: err_n = 1'b1;
          endcase
        end
        ST_SEL: begin
          sel_n = in_byte; st_n = ST_WORD; kind_n = K_CP;
        end
        ST_WORD: if (word_done) begin
          case (kind_q)
            K_BP: begin
              emit = 1'b1; e_space = SP_BP;
              e_addr = ADDR_W'(word[31:24]); e_data = {8'h00, word[23:0]};
              st_n = ST_OP;
            end
            K_CP: begin
              emit = 1'b1; e_space = SP_CP; e_region = cp_region;
              e_addr = ADDR_W'(sel_q); e_data = word;
              st_n = ST_OP;
            end
            K_XFHDR: begin
              xa_n = word[15:0]; xl_n = word[31:16]; kind_n = K_XFDAT;
            end
            default: begin
              emit = xf_hit; e_space = SP_XF; e_region = xf_region;
              e_addr = ADDR_W'(xa_q); e_data = word;
              xa_n = xa_q + 16'd1;
              if (xl_q == 16'd0) st_n = ST_OP;
              else               xl_n = xl_q - 16'd1;
            end
          endcase
        end
        default: st_n = ST_OP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OP; kind_q <= K_BP; sel_q <= '0;
      xa_q <= '0; xl_q <= '0; err_q <= 1'b0;
    end else if (take) begin
      st_q <= st_n; kind_q <= kind_n; sel_q <= sel_n;
      xa_q <= xa_n; xl_q <= xl_n; err_q <= err_n;
    end
  end

  cmdq_out_stage #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(emit), .space_i(e_space),
    .addr_i(e_addr), .data_i(e_data), .region_i(e_region),
    .ready_i(wr_ready), .valid_o(wr_valid), .space_o(o_space),
    .addr_o(wr_addr), .data_o(wr_data), .region_o(o_region), .free_o(in_ready));

  assign wr_space  = o_space;
  assign wr_region = o_region;
  assign err_flag  = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R8
  AST_XF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space == 2'd0 |->
      (wr_addr < 16'h0680) || (wr_addr >= 16'h1000 && wr_addr < 16'h1050)); // R6
  AST_LIGHT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space == 2'd0 && wr_region == 3'd3 |->
      wr_addr >= 16'h0600 && wr_addr < 16'h0680); // R5
  AST_BP_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space == 2'd1 |-> wr_data[31:24] == 8'h00 && wr_addr[15:8] == 8'h00); // R2
  AST_NOP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && st_q == ST_OP && in_byte == OP_NOP |=> st_q == ST_OP && !emit); // R7
endmodule

// File: tb/tb_cmdq_decoder.sv
`timescale 1ns/1ps
module tb_cmdq_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic wr_ready = 1'b1;
  logic in_ready, wr_valid, err_flag;
  logic [1:0] wr_space;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [2:0] wr_region;

  always #2 clk = ~clk;

  cmdq_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_region(wr_region), .err_flag(err_flag));

  int n_checks = 0, n_fail = 0, n_xfer = 0;
  bit stall_mode = 0, done = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [1:0]  q_sp[$];
  logic [15:0] q_ad[$];
  logic [31:0] q_dt[$];
  logic [2:0]  q_rg[$];
  string       q_tag[$];
  bit prev_stall = 0;
  logic [15:0] p_ad; logic [31:0] p_dt;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  function automatic int xf_rg(input logic [15:0] a);
    if (a < 16'h0400) return 0;
    if (a < 16'h0500) return 1;
    if (a < 16'h0600) return 2;
    if (a < 16'h0680) return 3;
    if (a >= 16'h1000 && a < 16'h1050) return 4;
    return -1;
  endfunction

  // monitor: ready pattern, transfer scoring, stall stability (R9)
  always @(negedge clk) begin
    if (stall_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_ready = lfsr[0] & lfsr[2];
    end else wr_ready = 1'b1;
    if (rst_n && prev_stall)
      chk(wr_valid && wr_addr == p_ad && wr_data == p_dt, "R9", "stalled write moved",
          {wr_addr, wr_data}, {p_ad, p_dt});
    prev_stall = wr_valid && !wr_ready;
    p_ad = wr_addr; p_dt = wr_data;
    if (rst_n && wr_valid && wr_ready) begin
      n_xfer++;
      if (q_sp.size() == 0)
        chk(0, "R6", "unexpected write", {wr_space, wr_addr, wr_data}, 64'h0);
      else begin
        logic [1:0] es; logic [15:0] ea; logic [31:0] ed; logic [2:0] er; string t;
        es = q_sp.pop_front(); ea = q_ad.pop_front(); ed = q_dt.pop_front();
        er = q_rg.pop_front(); t = q_tag.pop_front();
        chk(wr_space == es && wr_addr == ea && wr_data == ed && wr_region == er, t,
            "write fields", {3'b0, wr_region, wr_space, wr_addr, wr_data},
            {3'b0, er, es, ea, ed});
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    #1;
    chk(in_ready == !(wr_valid && !wr_ready), "R9", "in_ready rule", in_ready, !(wr_valid && !wr_ready));
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);  // R10 big-endian order
    send(w[31:24]); send(w[23:16]); send(w[15:8]); send(w[7:0]);
  endtask

  task automatic expect_wr(input logic [1:0] s, input logic [15:0] a, input logic [31:0] d,
                           input logic [2:0] r, input string t);
    q_sp.push_back(s); q_ad.push_back(a); q_dt.push_back(d); q_rg.push_back(r); q_tag.push_back(t);
  endtask

  task automatic bp(input logic [31:0] w);
    expect_wr(2'd1, {8'h00, w[31:24]}, {8'h00, w[23:0]}, 3'd7, "R2");
    send(8'h61); send_word(w);
  endtask

  task automatic cp(input logic [7:0] s, input logic [31:0] w);
    logic [2:0] r;
    r = 3'd7;
    if (s[3:0] < 4 && s[7:4] == 4'd10) r = 3'd5;
    if (s[3:0] < 4 && s[7:4] == 4'd11) r = 3'd6;
    expect_wr(2'd2, {8'h00, s}, w, r, "R3");
    send(8'h08); send(s); send_word(w);
  endtask

  task automatic xf(input logic [15:0] a0, input int cnt, input logic [31:0] seed);
    logic [15:0] a;
    send(8'h10); send_word({16'(cnt - 1), a0});
    for (int k = 0; k < cnt; k++) begin
      a = a0 + 16'(k);
      if (xf_rg(a) >= 0) expect_wr(2'd0, a, seed ^ (32'(k) * 32'h01010101), 3'(xf_rg(a)), "R5");
      send_word(seed ^ (32'(k) * 32'h01010101));
    end
  endtask

  task automatic drain();
    while (q_sp.size() != 0 || wr_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_valid && !err_flag && in_ready, "R1", "reset state",
        {wr_valid, err_flag, in_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: no-ops
    for (int i = 0; i < 6; i++) send(8'h00);
    repeat (5) @(negedge clk);
    chk(n_xfer == 0, "R7", "no-op produced write", n_xfer, 0);
    chk(err_flag == 1'b0, "R7", "no-op raised error", err_flag, 0);

    // R2, R10: back-end writes
    bp(32'h11223344);
    for (int i = 0; i < 256; i += 15) bp({8'(i), 24'(i * 32'h00A5A5B1)});
    drain();

    // R3: every selector byte
    for (int s = 0; s < 256; s++) cp(8'(s), 32'hC0DE0000 | 32'(s));
    drain();

    // R4, R5: region boundary sweeps
    xf(16'h03FE, 4, 32'h0BADF00D);
    xf(16'h04FE, 4, 32'h12345678);
    xf(16'h05FE, 4, 32'h9ABCDEF0);
    for (int a = 0; a < 16'h0700; a += 16'h0040) xf(16'(a), 2, 32'(a));
    drain();

    // R6: rejected words consumed, the rest continue
    base = n_xfer;
    xf(16'h067E, 4, 32'hAAAA5555);
    xf(16'h0FFF, 2, 32'h5555AAAA);
    xf(16'h104E, 3, 32'h01234567);
    xf(16'h2000, 3, 32'h76543210);
    drain();
    chk(n_xfer - base == 5, "R6", "writes from partly rejected packets", n_xfer - base, 5);

    // R4: wrap of 16-bit address
    xf(16'hFFFF, 2, 32'hFEEDFACE);
    drain();

    // R9: downstream backpressure
    stall_mode = 1;
    xf(16'h05F0, 40, 32'h3C3C3C3C);
    for (int s = 160; s < 192; s++) cp(8'(s), 32'(s) << 8);
    for (int i = 0; i < 20; i++) bp(32'(i) * 32'h0F1E2D3C);
    drain();
    stall_mode = 0;
    repeat (3) @(negedge clk);

    // R8: unknown opcodes set sticky error and are dropped
    chk(err_flag == 1'b0, "R8", "error before bad opcode", err_flag, 0);
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h00 || op == 8'h08 || op == 8'h10 || op == 8'h61) continue;
      send(8'(op));
      if (op == 1) begin
        repeat (2) @(negedge clk);
        chk(err_flag == 1'b1, "R8", "error after bad opcode", err_flag, 1);
      end
      bp({8'(op), 24'h00BEEF});
    end
    drain();
    send(8'h00);
    cp(8'hA2, 32'h00000042);
    drain();
    chk(err_flag == 1'b1, "R8", "error not sticky", err_flag, 1);
    chk(q_sp.size() == 0, "R4", "expected writes missing", q_sp.size(), 0);

    done = 1;
    report();
  end
endmodule